// File: doc/BRIEF.md
# Card Presence and Interface Mode Controller

This block decides whether a CompactFlash card is seated in its socket and holds the register that configures the card interface. Two active-low detect pins from the socket are synchronised and then debounced. The card counts as present only while both pins read low. Each debounced change of presence, whether an insertion or a removal, raises a one-cycle event toward the interrupt logic. A status word reports the synchronised pin levels, the ready inputs and the debounced presence.

The mode register selects the interface personality (memory, I/O or true-IDE) and the card type. It drives the card reset and output tri-state controls, enables the two DMA flavours and selects the data-request block size. It also carries the host enable. When software moves the host enable from one to zero, the block issues a one-cycle flush toward the transfer engine, which acts as a soft reset of that engine. The card reset output is a plain register bit. Software times the reset pulse (at least 200 µs) itself.

Top module: `cf_presence_ctrl`

## Requirements
- R1: After a synchronous reset, the mode register reads 0, every control output is low, presence is 0 and no event is pending.
- R2: Presence becomes 1 only when both detect pins are low. A high level on either pin means the card is absent.
- R3: Presence changes only after the synchronised candidate level has held for DEBOUNCE_CYCLES consecutive clocks. The new value appears DEBOUNCE_CYCLES+2 clocks after the pin change. A disturbance of DEBOUNCE_CYCLES-1 clocks or less leaves presence unchanged.
- R4: Every change of debounced presence, insertion or removal, produces a `detect_evt_o` pulse exactly one clock long, in the same cycle as the change.
- R5: The status word (index 0) has the following layout, and all other bits read 0. The pin and ready bits lag their inputs by two clocks.

  | Bit | Content |
  |-----|---------|
  | 0 | Debounced presence |
  | 2 | Synchronised detect pin 1 |
  | 3 | Synchronised detect pin 2 |
  | 5 | Card ready |
  | 6 | I/O ready |
- R6: The mode register (index 3) has the fields below. The unused bits read 0. Each field drives its output from the clock after the write.

  | Bits | Field |
  |------|-------|
  | 1:0 | Interface mode: 0 memory, 1 I/O, 2 true-IDE |
  | 2 | Extended card type |
  | 3 | Card reset |
  | 4 | Host enable |
  | 5 | Output tri-state |
  | 8 | Ultra DMA enable |
  | 9 | Multiword DMA enable |
  | 12:11 | Block size: 0=512, 1=1024, 2=2048, 3=4096 bytes |
- R7: A write carrying mode code 3 leaves the interface mode field at its previous value, while the other fields of that write still take effect.
- R8: `card_reset_o` equals mode bit 3 with no timing of its own. It stays asserted until software clears it.
- R9: A write that moves host enable from 1 to 0 gives a one-clock `xfer_flush_o` pulse in the clock after the write. A write that leaves host enable at 0, or leaves it at 1, gives none.
- R10: Writes to the status index or to any index other than 3 change no mode field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cd1_n_i | input | 1 | Socket detect pin 1, active low, asynchronous |
| cd2_n_i | input | 1 | Socket detect pin 2, active low, asynchronous |
| card_ready_i | input | 1 | Card ready level, asynchronous |
| io_ready_i | input | 1 | I/O ready level, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_idx_i | input | 4 | Word index of the register accessed |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for `reg_idx_i` (combinational) |
| card_present_o | output | 1 | Debounced presence |
| detect_evt_o | output | 1 | One-cycle presence change event |
| if_mode_o | output | 2 | Interface mode code |
| card_plus_o | output | 1 | Extended card type selected |
| card_reset_o | output | 1 | Card reset control |
| host_enable_o | output | 1 | Host enable |
| outputs_tristate_o | output | 1 | Tri-state the card-side outputs |
| udma_en_o | output | 1 | Ultra DMA enable |
| mwdma_en_o | output | 1 | Multiword DMA enable |
| drq_block_o | output | 2 | Block size code |
| xfer_flush_o | output | 1 | One-cycle transfer-engine soft reset |

## Verification
The debounced presence flip and a mode register write that clears host enable are independent paths, and both can land on the same clock edge. The bench times a write so that it hits exactly the edge on which a re-insertion completes its debounce. It then checks in the following cycle that presence, the detect event, the flush pulse and the new mode fields all show together, with neither path masking the other.

// File: rtl/cf_pres_pkg.sv
// Package: shared constants, register indices, and the mode register
// type with its pack/unpack helpers. Assumes a 16-bit register data path.
package cf_pres_pkg;

    localparam int DATA_W = 16;
    localparam int IDX_W  = 4;

    localparam logic [IDX_W-1:0] IDX_STATUS = 4'd0;
    localparam logic [IDX_W-1:0] IDX_MODE   = 4'd3;

    // Mode register bit positions (software-visible layout)
    localparam int B_MODE_LO  = 0;
    localparam int B_PLUS     = 2;
    localparam int B_CRST     = 3;
    localparam int B_HOST_EN  = 4;
    localparam int B_TRISTATE = 5;
    localparam int B_UDMA     = 8;
    localparam int B_MWDMA    = 9;
    localparam int B_BLK_LO   = 11;

    // Status word bit positions
    localparam int S_PRESENT = 0;
    localparam int S_CD1     = 2;
    localparam int S_CD2     = 3;
    localparam int S_READY   = 5;
    localparam int S_IORDY   = 6;

    typedef enum logic [1:0] {
        IF_MEMORY   = 2'd0,
        IF_IO       = 2'd1,
        IF_TRUE_IDE = 2'd2,
        IF_RSVD     = 2'd3
    } if_mode_e;

    typedef struct packed {
        logic [1:0] drq_blk;
        logic       mwdma;
        logic       udma;
        logic       tristate;
        logic       host_en;
        logic       card_rst;
        logic       card_plus;
        if_mode_e   mode;
    } mode_reg_t;

    // Build the readback word from the stored fields
    function automatic logic [DATA_W-1:0] pack_mode(input mode_reg_t m);
        logic [DATA_W-1:0] w;
        w = '0;
        w[B_MODE_LO +: 2]  = m.mode;
        w[B_PLUS]          = m.card_plus;
        w[B_CRST]          = m.card_rst;
        w[B_HOST_EN]       = m.host_en;
        w[B_TRISTATE]      = m.tristate;
        w[B_UDMA]          = m.udma;
        w[B_MWDMA]         = m.mwdma;
        w[B_BLK_LO +: 2]   = m.drq_blk;
        return w;
    endfunction

    // Extract fields from a written word
    function automatic mode_reg_t unpack_mode(input logic [DATA_W-1:0] w);
        mode_reg_t m;
        m.mode      = if_mode_e'(w[B_MODE_LO +: 2]);
        m.card_plus = w[B_PLUS];
        m.card_rst  = w[B_CRST];
        m.host_en   = w[B_HOST_EN];
        m.tristate  = w[B_TRISTATE];
        m.udma      = w[B_UDMA];
        m.mwdma     = w[B_MWDMA];
        m.drq_blk   = w[B_BLK_LO +: 2];
        return m;
    endfunction

endpackage

// File: rtl/cf_sync_2ff.sv
// Two-flop synchroniser, one independent chain per bit.
// Assumes each bit is a slow level; no multi-bit coherency is implied.
module cf_sync_2ff #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic meta_q;
        logic sync_q;

        // Two-stage capture of an asynchronous level
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[b];
                sync_q <= RST_VAL[b];
            end else begin
                meta_q <= d_i[b];
                sync_q <= meta_q;
            end
        end

        assign q_o[b] = sync_q;
    end

endmodule

// File: rtl/cf_detect_debounce.sv
// Presence debouncer: the candidate (both synchronised detect pins low)
// must differ from the held presence for DEB_CYCLES consecutive clocks
// before presence flips; the flip raises a one-clock change pulse.
// Assumes synchronised inputs and DEB_CYCLES >= 1.
module cf_detect_debounce #(
    parameter int DEB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cd1_n_s,
    input  logic cd2_n_s,
    output logic present_o,
    output logic change_o
);

    localparam int CNT_W = (DEB_CYCLES < 2) ? 1 : $clog2(DEB_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYCLES - 1);

    logic             cand;
    logic             present_q;
    logic             change_q;
    logic [CNT_W-1:0] cnt_q;

    // Seated only when both pins are pulled low
    assign cand = ~cd1_n_s & ~cd2_n_s;

    // Count consecutive disagreeing samples and flip presence at the limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            present_q <= 1'b0;
            change_q  <= 1'b0;
            cnt_q     <= '0;
        end else begin
            change_q <= 1'b0;
            if (cand == present_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CNT_LAST) begin
                present_q <= cand;
                change_q  <= 1'b1;
                cnt_q     <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign present_o = present_q;
    assign change_o  = change_q;

endmodule

// File: rtl/cf_mode_regs.sv
// Mode register: stores interface mode, card type, reset, enable,
// tri-state, DMA enables and block size. A reserved mode code keeps the
// old mode; a 1->0 host enable write emits a one-clock flush.
// Assumes wr_i is already qualified by the register index.
module cf_mode_regs
    import cf_pres_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output mode_reg_t         mode_o,
    output logic              flush_o
);

    mode_reg_t mode_q;
    mode_reg_t mode_new;
    logic      flush_q;

    // Merge a write, rejecting the reserved interface code
    always_comb begin
        mode_new = unpack_mode(wdata_i);
        if (mode_new.mode == IF_RSVD) begin
            mode_new.mode = mode_q.mode;
        end
    end

    // Register update and soft-reset pulse generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            flush_q <= 1'b0;
        end else begin
            flush_q <= wr_i & mode_q.host_en & ~mode_new.host_en;
            if (wr_i) begin
                mode_q <= mode_new;
            end
        end
    end

    assign mode_o  = mode_q;
    assign flush_o = flush_q;

    logic unused_wbits;
    assign unused_wbits = ^{wdata_i[DATA_W-1:13], wdata_i[10], wdata_i[7:6]};

endmodule

// File: rtl/cf_presence_ctrl.sv
// Top: card presence detection and interface mode control.
// Synchronises socket pins and ready levels, debounces presence,
// exposes a status word and the mode register, drives the mode controls.
// Assumes a single-cycle register write strobe and combinational reads.
module cf_presence_ctrl
    import cf_pres_pkg::*;
#(
    parameter int DEBOUNCE_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cd1_n_i,
    input  logic              cd2_n_i,
    input  logic              card_ready_i,
    input  logic              io_ready_i,
    input  logic              reg_wr_i,
    input  logic [IDX_W-1:0]  reg_idx_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              card_present_o,
    output logic              detect_evt_o,
    output logic [1:0]        if_mode_o,
    output logic              card_plus_o,
    output logic              card_reset_o,
    output logic              host_enable_o,
    output logic              outputs_tristate_o,
    output logic              udma_en_o,
    output logic              mwdma_en_o,
    output logic [1:0]        drq_block_o,
    output logic              xfer_flush_o
);

    logic [1:0] cd_n_s;
    logic [1:0] rdy_s;
    logic       present;
    logic       mode_wr;
    mode_reg_t  mode;
    logic [DATA_W-1:0] status_w;

    // Detect pins reset to "absent" so no spurious insertion is seen
    cf_sync_2ff #(.W(2), .RST_VAL(2'b11)) u_sync_cd (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cd2_n_i, cd1_n_i}),
        .q_o   (cd_n_s)
    );

    // Ready levels reset to "not ready"
    cf_sync_2ff #(.W(2), .RST_VAL(2'b00)) u_sync_rdy (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({io_ready_i, card_ready_i}),
        .q_o   (rdy_s)
    );

    cf_detect_debounce #(.DEB_CYCLES(DEBOUNCE_CYCLES)) u_debounce (
        .clk       (clk),
        .rst_n     (rst_n),
        .cd1_n_s   (cd_n_s[0]),
        .cd2_n_s   (cd_n_s[1]),
        .present_o (present),
        .change_o  (detect_evt_o)
    );

    assign mode_wr = reg_wr_i && (reg_idx_i == IDX_MODE);

    cf_mode_regs u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (mode_wr),
        .wdata_i (reg_wdata_i),
        .mode_o  (mode),
        .flush_o (xfer_flush_o)
    );

    // Assemble the status word
    always_comb begin
        status_w            = '0;
        status_w[S_PRESENT] = present;
        status_w[S_CD1]     = cd_n_s[0];
        status_w[S_CD2]     = cd_n_s[1];
        status_w[S_READY]   = rdy_s[0];
        status_w[S_IORDY]   = rdy_s[1];
    end

    // Read multiplexer
    always_comb begin
        unique case (reg_idx_i)
            IDX_STATUS: reg_rdata_o = status_w;
            IDX_MODE:   reg_rdata_o = pack_mode(mode);
            default:    reg_rdata_o = '0;
        endcase
    end

    assign card_present_o     = present;
    assign if_mode_o          = mode.mode;
    assign card_plus_o        = mode.card_plus;
    assign card_reset_o       = mode.card_rst;
    assign host_enable_o      = mode.host_en;
    assign outputs_tristate_o = mode.tristate;
    assign udma_en_o          = mode.udma;
    assign mwdma_en_o         = mode.mwdma;
    assign drq_block_o        = mode.drq_blk;

endmodule

// File: rtl/cf_presence_ctrl_chk.sv
// Checker for cf_presence_ctrl: temporal properties on events, flush
// and mode register stability. Attached by bind below.
module cf_presence_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr_i,
    input logic [3:0] reg_idx_i,
    input logic       card_present_o,
    input logic       detect_evt_o,
    input logic [1:0] if_mode_o,
    input logic       host_enable_o,
    input logic       xfer_flush_o
);

    // R4
    evt_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        detect_evt_o |=> !detect_evt_o);

    // R4
    presence_change_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (card_present_o != $past(card_present_o)) |-> detect_evt_o);

    // R7
    mode_not_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        if_mode_o != 2'b11);

    // R9
    flush_after_enable_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_flush_o |-> (!host_enable_o && $past(host_enable_o)));

    // R9
    enable_drop_flushes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_enable_o) |-> xfer_flush_o);

    // R10
    mode_stable_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_wr_i && (reg_idx_i == 4'd3)) |-> $stable({if_mode_o, host_enable_o}));

endmodule

bind cf_presence_ctrl cf_presence_ctrl_chk u_chk (.*);

// File: tb/cf_presence_ctrl_bench.sv
// Bench: mode register vector table, then directed presence, debounce,
// status, ignored-write and same-cycle tests.
module cf_presence_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEB        = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cd1_n = 1'b1;
    logic        cd2_n = 1'b1;
    logic        rdy = 1'b0;
    logic        iordy = 1'b0;
    logic        wr = 1'b0;
    logic [3:0]  idx = 4'd3;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        present, evt, plus, crst, hen, tri_o, udma, mwdma, flush;
    logic [1:0]  mode, blk;

    int checks = 0;
    int fails  = 0;
    int evt_count = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cf_presence_ctrl #(.DEBOUNCE_CYCLES(DEB)) u_cf_presence_ctrl (
        .clk(clk), .rst_n(rst_n), .cd1_n_i(cd1_n), .cd2_n_i(cd2_n),
        .card_ready_i(rdy), .io_ready_i(iordy), .reg_wr_i(wr),
        .reg_idx_i(idx), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .card_present_o(present), .detect_evt_o(evt), .if_mode_o(mode),
        .card_plus_o(plus), .card_reset_o(crst), .host_enable_o(hen),
        .outputs_tristate_o(tri_o), .udma_en_o(udma), .mwdma_en_o(mwdma),
        .drq_block_o(blk), .xfer_flush_o(flush)
    );

    // Count event pulses away from the active edge
    always @(negedge clk) if (rst_n && evt) evt_count++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_reg(input logic [3:0] i, output logic [15:0] v);
        idx = i;
        #1 v = rdata;
    endtask

    task automatic write_reg(input logic [3:0] i, input logic [15:0] d);
        @(negedge clk);
        wr = 1'b1; idx = i; wdata = d;
        @(negedge clk);
        wr = 1'b0; idx = 4'd3;
    endtask

    // {write data, expected readback, expected flush}
    localparam logic [32:0] VEC [0:5] = '{
        {16'h0012, 16'h0012, 1'b0},
        {16'h0811, 16'h0811, 1'b0},
        {16'h1B3E, 16'h1B3E, 1'b0},
        {16'hFFFF, 16'h1B3E, 1'b0},
        {16'hE4C0, 16'h0000, 1'b1},
        {16'h1003, 16'h1000, 1'b0}
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        read_reg(4'd3, v);
        check("R1 mode reg", v, 16'h0000);
        check("R1 controls", {crst, hen, tri_o, udma, mwdma, plus, mode, blk, flush},
              '0);
        check("R1 presence/event", {present, evt}, 2'b00);
        read_reg(4'd0, v);
        check("R5 status after reset", v, 16'h000C);

        // R6 R7 R8 R9 table walk
        for (int k = 0; k < 6; k++) begin
            write_reg(4'd3, VEC[k][32:17]);
            read_reg(4'd3, v);
            check("R6 R7 readback", v, VEC[k][16:1]);
            check("R9 flush", flush, VEC[k][0]);
            check("R8 card reset follows bit3", crst, VEC[k][4]);
            check("R6 mode output", mode, VEC[k][2:1]);
            check("R6 block output", blk, VEC[k][13:12]);
            @(negedge clk);
            check("R9 flush one cycle", flush, 1'b0);
        end

        // R10 writes elsewhere ignored
        write_reg(4'd0, 16'hFFFF);
        write_reg(4'd7, 16'hFFFF);
        read_reg(4'd3, v);
        check("R10 mode unchanged", v, 16'h1000);
        check("R10 outputs unchanged", {hen, crst, mode}, 4'b0000);

        // R5 status lag and layout, R2 one pin low is absent
        @(negedge clk);
        cd1_n = 1'b0; rdy = 1'b1;
        repeat (2) @(negedge clk);
        read_reg(4'd0, v);
        check("R5 status one pin low", v, 16'h0028);
        repeat (DEB + 3) @(negedge clk);
        check("R2 one pin low absent", present, 1'b0);

        // R3 short glitch ignored
        cd2_n = 1'b0;
        repeat (DEB - 1) @(negedge clk);
        cd2_n = 1'b1;
        repeat (2 * DEB) @(negedge clk);
        check("R3 glitch presence", present, 1'b0);
        check("R3 glitch no event", evt_count, 0);

        // R2 R3 R4 insertion timing
        cd2_n = 1'b0;
        repeat (DEB + 1) @(negedge clk);
        check("R3 not yet present", present, 1'b0);
        @(negedge clk);
        check("R2 present after debounce", present, 1'b1);
        check("R4 insertion event", evt, 1'b1);
        @(negedge clk);
        check("R4 event one cycle", evt, 1'b0);
        read_reg(4'd0, v);
        check("R5 status present", v, 16'h0021);

        // R2 R4 removal via one pin
        cd1_n = 1'b1; iordy = 1'b1;
        repeat (DEB + 1) @(negedge clk);
        check("R3 still present", present, 1'b1);
        @(negedge clk);
        check("R2 removal", present, 1'b0);
        check("R4 removal event", evt, 1'b1);
        @(negedge clk);
        read_reg(4'd0, v);
        check("R5 status removed", v, 16'h0064);
        check("R4 event count", evt_count, 2);

        // Same cycle: presence flip and host enable clear
        write_reg(4'd3, 16'h0012);
        cd1_n = 1'b0;
        repeat (DEB + 1) @(negedge clk);
        wr = 1'b1; idx = 4'd3; wdata = 16'h0002;
        @(negedge clk);
        wr = 1'b0;
        check("R4 concurrent event", {present, evt}, 2'b11);
        check("R9 concurrent flush", {flush, hen}, 2'b10);
        check("R6 concurrent mode", mode, 2'd2);
        @(negedge clk);
        check("R4 event total", evt_count, 3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule